// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block generates a programmable square-wave output from a 32.768 kHz base clock. A two-bit source field chooses the rate the divider steps at: the base clock itself, or one of three slower rates supplied as single-cycle strobes in the base clock domain. A three-bit ratio field then divides that source by 1, 2, 3, 5, 6, 10, 15 or 30. The ratio fixes the high fraction of each output period at one half, one third or one fifth.

Each slower rate arrives as a half-period strobe, meaning one pulse per half cycle of the source (2048 Hz for the 1024 Hz source, 64 Hz for 32 Hz, 2 Hz for 1 Hz). This lets a divide-by-one output on a slow source keep an even duty. On the base source, the divider steps once per clock. A divide-by-one setting there, and the override forced by the frequency-control pin, pass the base clock straight to the output.

The output is driven only while the output-enable pin is high. When the frequency-control pin is high, the enable bit must also be set. The data output is held low whenever the driver is off, so the pad can be built from `fout_data` and `fout_oe`.

Top module: `clkout_div`

## Requirements
- R1: With `freq_ctl` low and `out_en` high, `fout_oe` is 1 and `fout_data` follows the base clock level, whatever `div_en` and `div_sel` hold.
- R2: With `freq_ctl` high and `div_en` low, `fout_oe` is 0.
- R3: With `out_en` low, `fout_oe` is 0 regardless of every other input.
- R4: `div_sel[4:3]` picks the step source. 00 steps on every base clock. 01 steps on `hstep_1k`, 10 on `hstep_32` and 11 on `hstep_1`. Strobes of the unselected sources do not move the output.
- R5: `div_sel[2:0]` picks the divide and high fraction: 000 /1 at 1/2, 001 /2 at 1/2, 010 /3 at 1/3, 011 /6 at 1/2, 100 /5 at 1/5, 101 /10 at 1/2, 110 /15 at 1/3, 111 /30 at 1/2. The output period is that many base clocks on source 00, or twice that many strobes on the slower sources. Each period starts with its high part.
- R6: With `div_sel` equal to 00000 and the output selected, `fout_data` follows the base clock level.
- R7: Any change of `div_sel` restarts the output period. After the next clock edge the output is at the first step of its high part.
- R8: Synchronous reset clears the phase, so the first step after reset starts a new period with its high part.
- R9: `fout_data` is 0 whenever `fout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz base clock |
| rst | input | 1 | Synchronous active-high reset |
| hstep_1k | input | 1 | Half-period strobe of the 1024 Hz source |
| hstep_32 | input | 1 | Half-period strobe of the 32 Hz source |
| hstep_1 | input | 1 | Half-period strobe of the 1 Hz source |
| freq_ctl | input | 1 | Low forces raw base clock; high selects the programmed output |
| out_en | input | 1 | Output-enable pin; low turns the driver off |
| div_en | input | 1 | Register bit enabling the programmed output |
| div_sel | input | 5 | [4:3] source select, [2:0] ratio select |
| fout_data | output | 1 | Output data, low while the driver is off |
| fout_oe | output | 1 | Output driver enable |

## Verification
The assertions assume that each strobe is one base clock wide and is sampled once per rising edge. They also assume that `div_sel` changes only between edges, so a restart is seen as a single-cycle mismatch with the captured selection. The bench drives every input in the low half of the clock and raises one group of strobes per cycle. It checks the output in the middle of a phase, never at an edge. On the slow sources it pulses the unselected strobes between real steps and confirms that the output pattern does not shift.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int PHASE_W = 6;
    localparam int RATIO_W = 3;

    typedef enum logic [1:0] {
        SRC_BASE = 2'b00,
        SRC_1K   = 2'b01,
        SRC_32   = 2'b10,
        SRC_1    = 2'b11
    } src_sel_e;

    typedef struct packed {
        src_sel_e           src;
        logic [RATIO_W-1:0] ratio;
    } div_cfg_t;

    typedef struct packed {
        logic [PHASE_W-1:0] period;
        logic [PHASE_W-1:0] high_len;
    } div_plan_t;

    // Period and high length in step units for a configuration.
    function automatic div_plan_t plan_of(div_cfg_t c);
        div_plan_t p;
        logic [PHASE_W-1:0] r;
        logic [PHASE_W-1:0] h;
        case (c.ratio)
            3'd0:    begin r = 6'd1;  h = 6'd1;  end
            3'd1:    begin r = 6'd2;  h = 6'd1;  end
            3'd2:    begin r = 6'd3;  h = 6'd1;  end
            3'd3:    begin r = 6'd6;  h = 6'd3;  end
            3'd4:    begin r = 6'd5;  h = 6'd1;  end
            3'd5:    begin r = 6'd10; h = 6'd5;  end
            3'd6:    begin r = 6'd15; h = 6'd5;  end
            default: begin r = 6'd30; h = 6'd15; end
        endcase
        if (c.src == SRC_BASE) begin
            p.period   = r;
            p.high_len = h;
        end else begin
            p.period   = r << 1;
            p.high_len = (c.ratio == 3'd0) ? 6'd1 : (h << 1);
        end
        return p;
    endfunction

    function automatic logic is_bypass(div_cfg_t c);
        return (c.src == SRC_BASE) && (c.ratio == '0);
    endfunction

endpackage

// File: rtl/cdiv_step_sel.sv
module cdiv_step_sel
    import clkdiv_pkg::*;
(
    input  src_sel_e src,
    input  logic     hstep_1k,
    input  logic     hstep_32,
    input  logic     hstep_1,
    output logic     unit_step
);
    always_comb begin
        case (src)
            SRC_BASE: unit_step = 1'b1;
            SRC_1K:   unit_step = hstep_1k;
            SRC_32:   unit_step = hstep_32;
            default:  unit_step = hstep_1;
        endcase
    end
endmodule

// File: rtl/cdiv_phase.sv
module cdiv_phase
    import clkdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  div_cfg_t           cfg,
    input  logic               unit_step,
    output logic [PHASE_W-1:0] phase,
    output logic               restart,
    output logic               level
);
    div_cfg_t  cfg_q;
    div_plan_t plan;

    assign plan    = plan_of(cfg);
    assign restart = (cfg != cfg_q);
    assign level   = (phase < plan.high_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            cfg_q <= cfg;
        end else if (restart) begin
            phase <= '0;
            cfg_q <= cfg;
        end else if (unit_step) begin
            if (phase >= plan.period - 1'b1)
                phase <= '0;
            else
                phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/cdiv_out_gate.sv
module cdiv_out_gate (
    input  logic clk,
    input  logic freq_ctl,
    input  logic div_en,
    input  logic out_en,
    input  logic bypass,
    input  logic level,
    output logic fout_data,
    output logic fout_oe
);
    logic drive;
    logic pick;

    assign drive     = out_en & (~freq_ctl | div_en);
    assign pick      = (~freq_ctl | bypass) ? clk : level;
    assign fout_oe   = drive;
    assign fout_data = drive & pick;
endmodule

// File: rtl/clkout_div.sv
module clkout_div
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hstep_1k,
    input  logic       hstep_32,
    input  logic       hstep_1,
    input  logic       freq_ctl,
    input  logic       out_en,
    input  logic       div_en,
    input  logic [4:0] div_sel,
    output logic       fout_data,
    output logic       fout_oe
);
    div_cfg_t           cfg;
    logic               unit_step;
    logic               restart;
    logic               level;
    logic [PHASE_W-1:0] phase;

    assign cfg.src   = src_sel_e'(div_sel[4:3]);
    assign cfg.ratio = div_sel[2:0];

    cdiv_step_sel u_step (
        .src       (cfg.src),
        .hstep_1k  (hstep_1k),
        .hstep_32  (hstep_32),
        .hstep_1   (hstep_1),
        .unit_step (unit_step)
    );

    cdiv_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .unit_step (unit_step),
        .phase     (phase),
        .restart   (restart),
        .level     (level)
    );

    cdiv_out_gate u_gate (
        .clk       (clk),
        .freq_ctl  (freq_ctl),
        .div_en    (div_en),
        .out_en    (out_en),
        .bypass    (is_bypass(cfg)),
        .level     (level),
        .fout_data (fout_data),
        .fout_oe   (fout_oe)
    );
endmodule

// File: rtl/clkout_div_chk.sv
module clkout_div_chk (
    input logic       clk,
    input logic       rst,
    input logic       freq_ctl,
    input logic       out_en,
    input logic       div_en,
    input logic       fout_data,
    input logic       fout_oe,
    input logic       unit_step,
    input logic       restart,
    input logic [5:0] phase
);
    p_pin_override_r1: assert property (@(posedge clk) disable iff (rst)
        (out_en && !freq_ctl) |-> fout_oe);

    p_fe_off_r2: assert property (@(posedge clk) disable iff (rst)
        (freq_ctl && !div_en) |-> !fout_oe);

    p_pin_off_r3: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> !fout_oe);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!unit_step && !restart) |=> $stable(phase));

    p_phase_range_r5: assert property (@(posedge clk) disable iff (rst)
        phase < 6'd60);

    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase == 6'd0));

    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !fout_oe |-> !fout_data);
endmodule

bind clkout_div clkout_div_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .freq_ctl  (freq_ctl),
    .out_en    (out_en),
    .div_en    (div_en),
    .fout_data (fout_data),
    .fout_oe   (fout_oe),
    .unit_step (unit_step),
    .restart   (restart),
    .phase     (phase)
);

// File: tb/sim_clkout_div.sv
module sim_clkout_div;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hstep_1k = 1'b0;
    logic       hstep_32 = 1'b0;
    logic       hstep_1 = 1'b0;
    logic       freq_ctl = 1'b1;
    logic       out_en = 1'b1;
    logic       div_en = 1'b1;
    logic [4:0] div_sel = 5'b00010;
    logic       fout_data;
    logic       fout_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    clkout_div u0 (
        .clk(clk), .rst(rst), .hstep_1k(hstep_1k), .hstep_32(hstep_32),
        .hstep_1(hstep_1), .freq_ctl(freq_ctl), .out_en(out_en),
        .div_en(div_en), .div_sel(div_sel),
        .fout_data(fout_data), .fout_oe(fout_oe)
    );

    // {div_sel, period in steps, high steps}
    localparam logic [16:0] VEC [13] = '{
        {5'b00001, 6'd2,  6'd1},
        {5'b00010, 6'd3,  6'd1},
        {5'b00011, 6'd6,  6'd3},
        {5'b00100, 6'd5,  6'd1},
        {5'b00101, 6'd10, 6'd5},
        {5'b00110, 6'd15, 6'd5},
        {5'b00111, 6'd30, 6'd15},
        {5'b01000, 6'd2,  6'd1},
        {5'b01100, 6'd10, 6'd2},
        {5'b10010, 6'd6,  6'd2},
        {5'b10110, 6'd30, 6'd10},
        {5'b11111, 6'd60, 6'd30},
        {5'b11101, 6'd20, 6'd10}
    };

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic pulse(input logic a, input logic b, input logic c);
        hstep_1k = a; hstep_32 = b; hstep_1 = c;
        step();
        hstep_1k = 1'b0; hstep_32 = 1'b0; hstep_1 = 1'b0;
    endtask

    // Checks output follows the clock in both phases.
    task automatic check_follow(input string req);
        @(posedge clk); #2;
        check(req, fout_data, 1'b1);
        check(req, fout_oe, 1'b1);
        @(negedge clk); #2;
        check(req, fout_data, 1'b0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0] f;
        int p;
        int h;
        logic [1:0] src;
        logic e;

        // R8: reset holds the phase at the start of the high part
        step(); step(); step();
        check("R8", fout_data, 1'b1);
        check("R8", fout_oe, 1'b1);
        rst = 1'b0;
        step(); check("R8", fout_data, 1'b0);
        step(); check("R8", fout_data, 1'b0);
        step(); check("R8", fout_data, 1'b1);

        // R4 R5 R7: table of settings
        for (int i = 0; i < 13; i++) begin
            f   = VEC[i][16:12];
            p   = int'(VEC[i][11:6]);
            h   = int'(VEC[i][5:0]);
            src = f[4:3];
            div_sel = f;
            step();
            for (int k = 0; k < 2 * p; k++) begin
                e = ((k % p) < h);
                check((k == 0) ? "R7" : "R5", fout_data, e);
                if (src == 2'b00) begin
                    step();
                end else begin
                    pulse(src != 2'b01, src != 2'b10, src != 2'b11);
                    check("R4", fout_data, e);
                    pulse(src == 2'b01, src == 2'b10, src == 2'b11);
                end
            end
        end

        // R7: change mid-period while low
        div_sel = 5'b00111;
        step();
        for (int k = 0; k < 20; k++) step();
        check("R7", fout_data, 1'b0);
        div_sel = 5'b00101;
        step();
        check("R7", fout_data, 1'b1);

        // R8: reset in the middle of a period
        div_sel = 5'b00011;
        step();
        for (int k = 0; k < 4; k++) step();
        check("R8", fout_data, 1'b0);
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R8", fout_data, 1'b1);
        step(); check("R8", fout_data, 1'b1);
        step(); check("R8", fout_data, 1'b1);
        step(); check("R8", fout_data, 1'b0);

        // R6: bypass setting
        div_sel = 5'b00000;
        check_follow("R6");
        check_follow("R6");

        // R1: pin override ignores register bits
        @(negedge clk); #1;
        freq_ctl = 1'b0; div_en = 1'b0; div_sel = 5'b11110;
        check_follow("R1");
        check_follow("R1");

        // R2 R9: enable bit off
        @(negedge clk); #1;
        freq_ctl = 1'b1; div_en = 1'b0;
        @(posedge clk); #2;
        check("R2", fout_oe, 1'b0);
        check("R9", fout_data, 1'b0);

        // R3 R9: output pin off
        @(negedge clk); #1;
        div_en = 1'b1; out_en = 1'b0; div_sel = 5'b00000;
        @(posedge clk); #2;
        check("R3", fout_oe, 1'b0);
        check("R9", fout_data, 1'b0);
        @(negedge clk); #1;
        freq_ctl = 1'b0;
        @(posedge clk); #2;
        check("R3", fout_oe, 1'b0);
        check("R9", fout_data, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule